// File: doc/BRIEF.md
# DMA Completion Interrupt Aggregator

This block gathers the one-cycle completion pulses of up to 32 DMA channels into a sticky status word. It combines that word with a per-channel enable mask to form a pending word, and drives a single level-sensitive interrupt line whenever any pending bit is set. Software reaches the three words through a small register-bus slave with an address, a write strobe, write data and combinational read data.

Channel `n` always maps to bit `n` of every word. A completion is always recorded, even when its channel is masked, so software can poll the raw status without taking interrupts. The interrupt handler reads the pending word to see which enabled channels need service, and then acknowledges them by writing ones to the status word. The registers sit at a high offset so that they stay clear of the per-channel register windows that share the same bus.

Top module: `dma_irq_agg`

## Requirements
- R1: Status is read and written at byte address 0x080000, pending at 0x080004 and enable at 0x080008. Any other address reads as 0, and writes to it change nothing.
- R2: A done pulse on channel n sets status bit n at the next clock edge, whatever the value of enable bit n.
- R3: A write to status clears every bit that is 1 in the write data. Bits written as 0 keep their value.
- R4: Writing 0xFFFFFFFF to status clears every flag.
- R5: A write to enable loads the mask from the write data. Writing 0 masks every channel, so pending reads 0 and the interrupt stays low.
- R6: Pending reads as status AND enable. Writing to the pending address changes neither status nor enable.
- R7: The interrupt output is registered. It goes high one cycle after pending becomes nonzero and low one cycle after the last pending bit clears.
- R8: If a done pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R9: Bits at or above the channel count read as 0 in all three words, even after ones are written there.
- R10: After reset, status, enable and pending read 0 and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_done | input | NUM_CH | One-cycle completion pulse, one bit per channel |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt, high while any enabled channel has a flag set |

## Verification
The main function is driven from a table of vectors. Each vector sets an enable mask, fires a completion pattern and applies an acknowledge pattern, then reads status, pending and the interrupt line. The patterns include a single channel, sparse and dense sets, a fully masked mask, and a clear that hits only some of the completed bits. Together they show whether a design ANDs the wrong words, drops masked completions, or clears bits it was not told to clear. Directed cases then cover the interrupt timing edge by edge, a completion and a clear landing on the same bit, writes to the pending address, writes to bits above the channel count, and unmapped addresses.

// File: rtl/dma_irq_agg_pkg.sv
package dma_irq_agg_pkg;

  localparam int unsigned REG_W = 32;

  // Byte offsets of the three words.
  localparam logic [31:0] OFF_STATUS  = 32'h0008_0000;
  localparam logic [31:0] OFF_PENDING = 32'h0008_0004;
  localparam logic [31:0] OFF_ENABLE  = 32'h0008_0008;

  typedef struct packed {
    logic hit_status;
    logic hit_pending;
    logic hit_enable;
  } reg_sel_t;

  // Mask with one bit per implemented channel.
  function automatic logic [REG_W-1:0] chan_mask(input int unsigned nch);
    logic [REG_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < REG_W; i++) begin
      if (i < nch) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Address compare; address is zero-extended by the caller.
  function automatic logic addr_hit(input logic [31:0] addr,
                                    input logic [31:0] off);
    return addr == off;
  endfunction

  // Bits to acknowledge on a status write.
  function automatic logic [REG_W-1:0] ack_bits(input logic wr,
                                                input logic [REG_W-1:0] data);
    return wr ? data : '0;
  endfunction

  // Pending view.
  function automatic logic [REG_W-1:0] pend_of(input logic [REG_W-1:0] st,
                                               input logic [REG_W-1:0] en);
    return st & en;
  endfunction

endpackage

// File: rtl/dma_irq_agg_decode.sv
module dma_irq_agg_decode
  import dma_irq_agg_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output reg_sel_t          sel_o,
  output logic              wr_status_o,
  output logic              wr_enable_o
);

  logic [31:0] addr_ext;

  assign addr_ext = 32'(addr_i);

  always_comb begin
    sel_o.hit_status  = addr_hit(addr_ext, OFF_STATUS);
    sel_o.hit_pending = addr_hit(addr_ext, OFF_PENDING);
    sel_o.hit_enable  = addr_hit(addr_ext, OFF_ENABLE);
  end

  // The pending word has no write path.
  assign wr_status_o = we_i & sel_o.hit_status;
  assign wr_enable_o = we_i & sel_o.hit_enable;

  always_comb begin
    assert_one_select_R1: assert ($onehot0({sel_o.hit_status, sel_o.hit_pending,
                                           sel_o.hit_enable}));
  end

endmodule

// File: rtl/dma_irq_agg_flags.sv
module dma_irq_agg_flags
  import dma_irq_agg_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_CH-1:0] done_i,
  input  logic [REG_W-1:0] ack_i,
  output logic [REG_W-1:0] status_o
);

  logic [REG_W-1:0] done_ext;

  assign done_ext = REG_W'(done_i);

  for (genvar g = 0; g < REG_W; g++) begin : g_bit
    if (g < NUM_CH) begin : g_live
      logic flag_q;
      always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (done_ext[g]) flag_q <= 1'b1;   // a new completion wins over an ack
        else if (ack_i[g])   flag_q <= 1'b0;
      end
      assign status_o[g] = flag_q;
    end else begin : g_tie
      assign status_o[g] = 1'b0;
    end
  end

  // R2: a completion is always latched, and R8: even against an ack.
  assert_done_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ext != '0) |=> ((status_o & $past(done_ext)) == $past(done_ext)));

  // R3: acknowledged bits without a new completion read 0 next cycle.
  assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_i & ~done_ext) != '0) |=> ((status_o & $past(ack_i & ~done_ext)) == '0));

  // R3: with no ack and no completion, status holds.
  assert_status_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i == '0 && done_ext == '0) |=> $stable(status_o));

endmodule

// File: rtl/dma_irq_agg_mask.sv
module dma_irq_agg_mask
  import dma_irq_agg_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_enable_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [REG_W-1:0] status_i,
  output logic [REG_W-1:0] enable_o,
  output logic [REG_W-1:0] pending_o,
  output logic             irq_o
);

  localparam logic [REG_W-1:0] LIVE = chan_mask(NUM_CH);

  logic [REG_W-1:0] enable_q;
  logic             irq_q;
  logic             any_pending;

  always_ff @(posedge clk) begin
    if (!rst_n)           enable_q <= '0;
    else if (wr_enable_i) enable_q <= wdata_i & LIVE;
  end

  assign pending_o   = pend_of(status_i, enable_q);
  assign any_pending = |pending_o;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_pending;
  end

  assign enable_o = enable_q;
  assign irq_o    = irq_q;

  // R5 / R6: the mask only moves on an enable write.
  assert_mask_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_enable_i |=> $stable(enable_o));

  // R7: the line rises one cycle after an enabled flag appears.
  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_i & enable_o) != '0) |=> irq_o);

  // R7: the line falls one cycle after nothing enabled is flagged.
  assert_irq_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_i & enable_o) == '0) |=> !irq_o);

endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import dma_irq_agg_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chan_done,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);

  localparam logic [REG_W-1:0] LIVE = chan_mask(NUM_CH);

  reg_sel_t         sel;
  logic             wr_status;
  logic             wr_enable;
  logic [REG_W-1:0] ack_vec;
  logic [REG_W-1:0] status_w;
  logic [REG_W-1:0] enable_w;
  logic [REG_W-1:0] pending_w;

  dma_irq_agg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i      (bus_addr),
    .we_i        (bus_we),
    .sel_o       (sel),
    .wr_status_o (wr_status),
    .wr_enable_o (wr_enable)
  );

  assign ack_vec = ack_bits(wr_status, bus_wdata & LIVE);

  dma_irq_agg_flags #(.NUM_CH(NUM_CH)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .done_i   (chan_done),
    .ack_i    (ack_vec),
    .status_o (status_w)
  );

  dma_irq_agg_mask #(.NUM_CH(NUM_CH)) u_mask (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_enable_i (wr_enable),
    .wdata_i     (bus_wdata),
    .status_i    (status_w),
    .enable_o    (enable_w),
    .pending_o   (pending_w),
    .irq_o       (irq)
  );

  always_comb begin
    unique case (1'b1)
      sel.hit_status:  bus_rdata = status_w;
      sel.hit_pending: bus_rdata = pending_w;
      sel.hit_enable:  bus_rdata = enable_w;
      default:         bus_rdata = '0;
    endcase
  end

  // R9: nothing above the channel count is ever visible.
  always_comb begin
    assert_no_ghost_bits_R9: assert ((bus_rdata & ~LIVE) == '0);
  end

  // R1: an access that hits no word reads 0.
  always_comb begin
    assert_unmapped_zero_R1: assert ((sel.hit_status | sel.hit_pending | sel.hit_enable)
                                     || bus_rdata == '0);
  end

  // R6: a write to the pending address leaves status alone.
  assert_pending_ro_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel.hit_pending && chan_done == '0) |=> $stable(status_w));

endmodule

// File: tb/dma_irq_agg_test.sv
module dma_irq_agg_test;

  localparam int unsigned NCH = 8;
  localparam logic [19:0] A_ST = 20'h80000;
  localparam logic [19:0] A_PD = 20'h80004;
  localparam logic [19:0] A_EN = 20'h80008;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] done;
  logic [19:0]    addr;
  logic           we;
  logic [31:0]    wdata;
  logic [31:0]    rdata;
  logic           irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dma_irq_agg #(.NUM_CH(NCH), .ADDR_W(20)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_done (done),
    .bus_addr  (addr),
    .bus_we    (we),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .irq       (irq)
  );

  // Fields: done[39:32] enable[31:24] ack[23:16] exp_status[15:8] exp_pending[7:0]
  localparam logic [39:0] VEC [6] = '{
    40'h01_01_00_01_01,
    40'hA5_0F_00_A5_05,
    40'hFF_00_0F_F0_00,
    40'h3C_FF_24_18_18,
    40'h80_80_80_00_00,
    40'hC3_41_02_C1_41
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [19:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse(input logic [NCH-1:0] m);
    @(negedge clk);
    done = m;
    @(negedge clk);
    done = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; done = '0; addr = '0; we = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(A_ST, v); chk("R10 status", v, 32'h0);
    rd(A_EN, v); chk("R10 enable", v, 32'h0);
    rd(A_PD, v); chk("R10 pending", v, 32'h0);
    chk("R10 irq", 32'(irq), 32'h0);

    // Table walk: R2 R3 R6 R7
    foreach (VEC[i]) begin
      wr(A_ST, 32'hFFFF_FFFF);
      wr(A_EN, {24'h0, VEC[i][31:24]});
      pulse(VEC[i][39:32]);
      wr(A_ST, {24'h0, VEC[i][23:16]});
      @(negedge clk);
      rd(A_ST, v); chk($sformatf("R3 vec%0d status", i), v, {24'h0, VEC[i][15:8]});
      rd(A_PD, v); chk($sformatf("R6 vec%0d pending", i), v, {24'h0, VEC[i][7:0]});
      chk($sformatf("R7 vec%0d irq", i), 32'(irq), 32'(VEC[i][7:0] != 8'h0));
    end

    // R4 clear all
    pulse(8'hFF);
    wr(A_ST, 32'hFFFF_FFFF);
    rd(A_ST, v); chk("R4 clear all", v, 32'h0);

    // R7 timing edge by edge
    wr(A_EN, 32'h1);
    pulse(8'h01);
    chk("R7 irq lags set", 32'(irq), 32'h0);
    @(negedge clk);
    chk("R7 irq high", 32'(irq), 32'h1);
    wr(A_ST, 32'h1);
    chk("R7 irq lags clear", 32'(irq), 32'h1);
    @(negedge clk);
    chk("R7 irq low", 32'(irq), 32'h0);

    // R8 completion and ack on the same bit
    @(negedge clk);
    addr = A_ST; wdata = 32'h4; we = 1'b1; done = 8'h04;
    @(negedge clk);
    we = 1'b0; done = '0; wdata = '0;
    rd(A_ST, v); chk("R8 done beats ack", v, 32'h4);
    wr(A_ST, 32'h4);

    // R2 completion while masked, R5 mask-all
    wr(A_EN, 32'h0);
    pulse(8'h30);
    @(negedge clk);
    rd(A_ST, v);  chk("R2 masked still latched", v, 32'h30);
    rd(A_PD, v);  chk("R5 pending masked", v, 32'h0);
    chk("R5 irq masked", 32'(irq), 32'h0);

    // R6 pending address is read only
    wr(A_EN, 32'h10);
    wr(A_PD, 32'hFFFF_FFFF);
    rd(A_EN, v); chk("R6 enable unchanged", v, 32'h10);
    rd(A_ST, v); chk("R6 status unchanged", v, 32'h30);
    rd(A_PD, v); chk("R6 pending value", v, 32'h10);

    // R9 ghost bits
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, v); chk("R9 enable upper", v, 32'hFF);
    pulse(8'h80);
    rd(A_ST, v); chk("R9 status upper", v, 32'hB0);

    // R1 unmapped addresses and writes there
    rd(20'h80010, v); chk("R1 unmapped read", v, 32'h0);
    rd(20'h00000, v); chk("R1 low alias read", v, 32'h0);
    wr(20'h8000C, 32'h0);
    wr(20'h00008, 32'h0);
    rd(A_EN, v); chk("R1 stray write enable", v, 32'hFF);
    rd(A_ST, v); chk("R1 stray write status", v, 32'hB0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule